// File: doc/BRIEF.md
# Bit Clock Direction Detector

This block sits in a codec's crystal clock domain and decides, once per cold reset, whether the codec produces the serial link's bit clock or only receives it. While the active-low cold reset of the link is held, it counts rising edges that some other device places on the bit clock pin. If at least a set number of edges (five by default) arrive before the reset is released, the codec takes the receiver role and never drives the pin. With fewer edges it takes the driver role. It then enables its output buffer and produces a bit clock at half the crystal rate.

The decision is kept until the next cold reset. In the driver role, a power-down request stops the generated clock and holds it low. The clock stays stopped until a warm reset, which is frame sync held high for a set number of crystal cycles, followed by sync falling. A codec in the receiver role ignores the same sequence. A separate power-on reset puts the block in a known state before the first cold reset, with the driver role as the default.

Top module: `bclk_role_detect`

## Requirements
- R1: If EDGE_MIN (5) or more rising edges of the bit clock pin are seen while the cold reset is held, then after release `role_consumer` is 1. While it is 1, `bclk_oe` and `bclk_out` stay 0.
- R2: If fewer than EDGE_MIN rising edges are seen, then after release `role_consumer` is 0 and `bclk_oe` is 1. `bclk_out` then changes level on every crystal clock edge, which is the crystal clock divided by two.
- R3: While the cold reset is held, `bclk_oe` and `bclk_out` are 0.
- R4: The edge count is cleared at each assertion of cold reset. A new cold reset under a different pin condition gives the new role, whatever role came before.
- R5: After power-on reset, and before any cold reset release is seen, `role_consumer` is 0 and `bclk_oe` is 0.
- R6: In the driver role, a one-cycle `pwrdn_req` stops `bclk_out` and holds it at 0, while `bclk_oe` stays 1.
- R7: After a stop, `sync_in` held high for at least WARM_CYC crystal cycles and then lowered makes `bclk_out` toggle again within a few cycles. The clock stays stopped while sync is still high.
- R8: After a stop, a `sync_in` pulse shorter than WARM_CYC crystal cycles does not restart the clock.
- R9: In the receiver role, the stop and warm reset sequence leaves `role_consumer` at 1, `bclk_oe` at 0 and `bclk_out` quiet.
- R10: The edge counter saturates at EDGE_MIN, so many more edges still give the receiver role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| bclk_pin | input | 1 | Bit clock pin level, asynchronous |
| link_rst_n | input | 1 | Link cold reset, active low, asynchronous |
| sync_in | input | 1 | Frame sync input, asynchronous |
| pwrdn_req | input | 1 | Power-down request, crystal domain |
| bclk_oe | output | 1 | Bit clock pin output enable |
| bclk_out | output | 1 | Generated bit clock |
| role_consumer | output | 1 | 1 = bit clock receiver, 0 = bit clock driver |

## Verification
A wrong edge count or a wrong comparison shows up within about ten crystal cycles after the cold reset is released. It appears as the wrong role flag and as an output enable that either rises or stays low. A stuck or wrongly sequenced stop and restart controller shows up within a twenty-cycle window of clock activity: the bit clock either keeps toggling after a power-down or stays quiet after a valid warm reset. A role that changes outside a cold reset shows up as an enabled pin driver on a receiver, or as a lost clock on a driver, at the next warm reset.

// File: rtl/bclk_role_pkg.sv
package bclk_role_pkg;
  typedef enum logic {
    ROLE_SOURCE   = 1'b0,
    ROLE_CONSUMER = 1'b1
  } role_e;

  typedef enum logic [1:0] {
    GS_RUN   = 2'd0,
    GS_HALT  = 2'd1,
    GS_ARMED = 2'd2
  } gen_state_e;
endpackage

// File: rtl/bclk_sync.sv
module bclk_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/bclk_edge_judge.sv
module bclk_edge_judge
  import bclk_role_pkg::*;
#(
  parameter int EDGE_MIN = 5,
  localparam int CW = $clog2(EDGE_MIN + 1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bclk_s,
  input  logic  crst_s,
  output role_e role,
  output logic  link_up
);
  logic          bclk_prev_q, bclk_prev_d;
  logic [CW-1:0] cnt_q, cnt_d;
  role_e         role_q, role_d;
  logic          up_q, up_d;
  logic          rise;

  assign rise = bclk_s & ~bclk_prev_q;

  always_comb begin
    bclk_prev_d = bclk_s;
    cnt_d       = cnt_q;
    role_d      = role_q;
    up_d        = crst_s;
    if (!crst_s) begin
      if (up_q) begin
        cnt_d = '0;
      end else if (rise && (cnt_q < CW'(EDGE_MIN))) begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (!up_q) begin
      role_d = (cnt_q >= CW'(EDGE_MIN)) ? ROLE_CONSUMER : ROLE_SOURCE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_prev_q <= 1'b0;
      cnt_q       <= '0;
      role_q      <= ROLE_SOURCE;
      up_q        <= 1'b0;
    end else begin
      bclk_prev_q <= bclk_prev_d;
      cnt_q       <= cnt_d;
      role_q      <= role_d;
      up_q        <= up_d;
    end
  end

  assign role    = role_q;
  assign link_up = up_q;

  p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(EDGE_MIN));
  p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !crst_s) |=> (cnt_q == '0));
  p_role_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && crst_s) |=> $stable(role_q));
endmodule

// File: rtl/bclk_gen.sv
module bclk_gen
  import bclk_role_pkg::*;
#(
  parameter int WARM_CYC = 200,
  localparam int WW = $clog2(WARM_CYC + 1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  role_e role,
  input  logic  link_up,
  input  logic  sync_s,
  input  logic  pwrdn_req,
  output logic  oe,
  output logic  bclk
);
  gen_state_e    st_q, st_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          tog_q, tog_d;
  logic          oe_q, oe_d;
  logic          drive;

  assign drive = link_up && (role == ROLE_SOURCE);

  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    if (!link_up) begin
      st_d   = GS_RUN;
      wcnt_d = '0;
    end else begin
      case (st_q)
        GS_RUN: begin
          wcnt_d = '0;
          if (pwrdn_req) st_d = GS_HALT;
        end
        GS_HALT: begin
          if (!sync_s) begin
            wcnt_d = '0;
          end else if (wcnt_q >= WW'(WARM_CYC - 1)) begin
            st_d = GS_ARMED;
          end else begin
            wcnt_d = wcnt_q + 1'b1;
          end
        end
        GS_ARMED: begin
          if (!sync_s) st_d = GS_RUN;
        end
        default: st_d = GS_RUN;
      endcase
    end
    oe_d  = drive;
    tog_d = (drive && (st_q == GS_RUN) && !pwrdn_req) ? ~tog_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= GS_RUN;
      wcnt_q <= '0;
      tog_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      tog_q  <= tog_d;
      oe_q   <= oe_d;
    end
  end

  assign oe   = oe_q;
  assign bclk = tog_q;

  p_pd_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && st_q == GS_RUN && pwrdn_req) |=> (st_q == GS_HALT));
  p_quiet_when_halted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != GS_RUN) |=> !tog_q);
  p_armed_needs_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GS_HALT && st_d == GS_ARMED) |-> sync_s);
endmodule

// File: rtl/bclk_role_detect.sv
module bclk_role_detect
  import bclk_role_pkg::*;
#(
  parameter int EDGE_MIN    = 5,
  parameter int WARM_CYC    = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_xtal,
  input  logic por_n,
  input  logic bclk_pin,
  input  logic link_rst_n,
  input  logic sync_in,
  input  logic pwrdn_req,
  output logic bclk_oe,
  output logic bclk_out,
  output logic role_consumer
);
  logic [2:0] async_in, sync_out;
  logic       bclk_s, crst_s, sync_s;
  role_e      role;
  logic       link_up;

  assign async_in = {sync_in, link_rst_n, bclk_pin};
  assign {sync_s, crst_s, bclk_s} = sync_out;

  bclk_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_xtal),
    .rst_n (por_n),
    .d     (async_in),
    .q     (sync_out)
  );

  bclk_edge_judge #(.EDGE_MIN(EDGE_MIN)) u_judge (
    .clk     (clk_xtal),
    .rst_n   (por_n),
    .bclk_s  (bclk_s),
    .crst_s  (crst_s),
    .role    (role),
    .link_up (link_up)
  );

  bclk_gen #(.WARM_CYC(WARM_CYC)) u_gen (
    .clk       (clk_xtal),
    .rst_n     (por_n),
    .role      (role),
    .link_up   (link_up),
    .sync_s    (sync_s),
    .pwrdn_req (pwrdn_req),
    .oe        (bclk_oe),
    .bclk      (bclk_out)
  );

  assign role_consumer = (role == ROLE_CONSUMER);

  p_consumer_quiet_r1: assert property (@(posedge clk_xtal) disable iff (!por_n)
    role_consumer |-> (!bclk_oe && !bclk_out));
  p_oe_low_in_reset_r3: assert property (@(posedge clk_xtal) disable iff (!por_n)
    $past(!crst_s, 2) |-> (!bclk_oe && !bclk_out));
endmodule

// File: tb/bclk_role_detect_test.sv
module bclk_role_detect_test;
  localparam int WARM = 200;

  logic clk_xtal = 1'b0;
  logic por_n, bclk_pin, link_rst_n, sync_in, pwrdn_req;
  logic bclk_oe, bclk_out, role_consumer;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_xtal = ~clk_xtal;

  bclk_role_detect #(.EDGE_MIN(5), .WARM_CYC(WARM)) uut (
    .clk_xtal      (clk_xtal),
    .por_n         (por_n),
    .bclk_pin      (bclk_pin),
    .link_rst_n    (link_rst_n),
    .sync_in       (sync_in),
    .pwrdn_req     (pwrdn_req),
    .bclk_oe       (bclk_oe),
    .bclk_out      (bclk_out),
    .role_consumer (role_consumer)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_xtal);
  endtask

  task automatic activity(output int changes);
    logic prev;
    changes = 0;
    prev = bclk_out;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_xtal);
      if (bclk_out != prev) changes++;
      prev = bclk_out;
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      bclk_pin = 1'b1; #20;
      bclk_pin = 1'b0; #20;
    end
  endtask

  task automatic cold_reset(input string req, input int edges, input bit exp_cons);
    int ch;
    link_rst_n = 1'b0;
    wait_cyc(10);
    chk("R3", "oe during reset", bclk_oe, 0);
    chk("R3", "bclk during reset", bclk_out, 0);
    pulses(edges);
    wait_cyc(10);
    link_rst_n = 1'b1;
    wait_cyc(10);
    chk(req, "role after release", role_consumer, exp_cons);
    chk(req, "oe after release", bclk_oe, exp_cons ? 0 : 1);
    activity(ch);
    chk(req, "bclk changes", ch, exp_cons ? 0 : 20);
  endtask

  task automatic warm_reset(input string req, input bit cons);
    int ch;
    @(negedge clk_xtal); pwrdn_req = 1'b1;
    @(negedge clk_xtal); pwrdn_req = 1'b0;
    wait_cyc(4);
    activity(ch);
    chk(cons ? req : "R6", "changes after power-down", ch, 0);
    chk(cons ? req : "R6", "level after power-down", bclk_out, 0);
    chk(cons ? req : "R6", "oe after power-down", bclk_oe, cons ? 0 : 1);
    sync_in = 1'b1; wait_cyc(50); sync_in = 1'b0;
    wait_cyc(10);
    activity(ch);
    chk(cons ? req : "R8", "changes after short sync", ch, 0);
    sync_in = 1'b1; wait_cyc(WARM + 20);
    activity(ch);
    chk(cons ? req : "R7", "changes while sync high", ch, 0);
    sync_in = 1'b0;
    wait_cyc(8);
    activity(ch);
    chk(req, "changes after warm reset", ch, cons ? 0 : 20);
    chk(req, "role after warm reset", role_consumer, cons ? 1 : 0);
    chk(req, "oe after warm reset", bclk_oe, cons ? 0 : 1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; bclk_pin = 1'b0; link_rst_n = 1'b0;
    sync_in = 1'b0; pwrdn_req = 1'b0;
    wait_cyc(5);
    por_n = 1'b1;
    wait_cyc(5);
    chk("R5", "role after power-on", role_consumer, 0);
    chk("R5", "oe after power-on", bclk_oe, 0);
    cold_reset("R2", 0, 1'b0);
    cold_reset("R2", 4, 1'b0);
    cold_reset("R1", 5, 1'b1);
    cold_reset("R10", 40, 1'b1);
    cold_reset("R4", 0, 1'b0);
    warm_reset("R7", 1'b0);
    cold_reset("R4", 7, 1'b1);
    warm_reset("R9", 1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule